// File: doc/BRIEF.md
# Primed Streaming DAC Playout Buffer

This block connects a streaming sample source to a DAC sample port. The source presents a valid/ready read port, much like the read side of a DMA queue. A transfer stage moves up to one sample per clock into a local single-clock FIFO. When the FIFO is full, the stage parks the offered sample in a hold register, drops `up_ready_o`, and offers that same sample again on every following cycle until the FIFO accepts it. No upstream sample is lost or skipped.

The playout stage takes one sample from the FIFO on each cycle where `dac_strobe_i` is high, but only after a start command has been latched. Controlling software can therefore fill the upstream queue and the local FIFO before the converter starts consuming samples. Once started, playout runs until synchronous reset. The transfer stage can fill the FIFO on every clock, and the DAC strobe is expected to fire at most every second clock, so a low FIFO refills faster than it drains.

Two sticky indicators report problems to the controller. The first records a strobe that found the FIFO empty. The second records an offer that was refused because the FIFO was full. Both stay set until `clear_flags_i` is asserted.

Top module: `dac_playout_buffer`

## Requirements
- R1: When no sample is held, `up_valid_i` is high and the FIFO is not full, that sample is written in the same cycle, and `level_o` rises by one at the next clock edge unless a sample is also played out in that cycle.
- R2: When `up_valid_i` is low and no sample is held, nothing is written and `level_o` does not increase.
- R3: `up_ready_o` is high exactly when no sample is held. A sample offered while the FIFO is full is captured and `up_ready_o` goes low on the next cycle. The captured sample is written on the first cycle in which the FIFO is not full, and `up_ready_o` returns high one cycle later.
- R4: Before the start command has been seen at a clock edge, strobes neither remove samples nor raise `dac_valid_o`. A strobe in the same cycle as the first `start_i` is also not served.
- R5: Once started, a strobe with a non-empty FIFO removes the oldest sample. `dac_data_o` shows that sample and `dac_valid_o` pulses high for one cycle, both one clock after the strobe. The start state stays latched until reset.
- R6: Once started, a strobe that finds the FIFO empty sets `underflow_o` at the next edge. `dac_data_o` keeps its last value (zero if nothing has played yet), and `level_o` is unchanged.
- R7: `underflow_o` stays set until `clear_flags_i` is high. If a new underflow event and a clear occur in the same cycle, the flag stays set.
- R8: `retry_o` is set one clock after any cycle in which a sample, whether direct or held, was offered while the FIFO was full. It clears only through `clear_flags_i`, and a new event in the same cycle takes priority over the clear.
- R9: `level_o` never exceeds DEPTH. `full_o` is high exactly when `level_o` equals DEPTH, and `empty_o` is high exactly when `level_o` is zero.
- R10: Samples leave on `dac_data_o` in the order they were accepted from upstream, with none dropped or duplicated.
- R11: After synchronous reset, the FIFO is empty, playout is not started, both flags are clear, `dac_data_o` is zero, `dac_valid_o` is low and `up_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid_i | input | 1 | Upstream sample present |
| up_data_i | input | SAMPLE_W | Upstream sample |
| up_ready_o | output | 1 | Block accepts an upstream sample this cycle |
| start_i | input | 1 | Start command, latched until reset |
| dac_strobe_i | input | 1 | DAC sample-rate enable |
| clear_flags_i | input | 1 | Clears both sticky indicators |
| dac_data_o | output | SAMPLE_W | Sample driven to the converter |
| dac_valid_o | output | 1 | Pulse: a new sample was played |
| underflow_o | output | 1 | Sticky: a strobe found the FIFO empty |
| retry_o | output | 1 | Sticky: an offer was refused because the FIFO was full |
| level_o | output | $clog2(DEPTH+1) | FIFO fill count |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |

## Verification
The bench fills the FIFO before start with upstream held valid. A design that fetched a new sample while one was held, or that overwrote the hold register, would lose or reorder samples, and the per-cycle model would expose that on `dac_data_o`. Strobes are sent before start and in the same cycle as start. A design that ignored priming would pulse `dac_valid_o` early. The bench then drains the FIFO under continued strobes. A design that moved its read pointer or changed `dac_data_o` on an empty read would show a wrong level or a changed output, and a design whose clear beat a concurrent set would drop a flag that should remain. A long random phase mixes a bursty source with strobes at varying rates, so the FIFO crosses its full and empty bounds many times.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

   // Transfer-stage state: direct pass-through or retrying a held sample
   typedef enum logic [0:0] {
      XS_DIRECT = 1'b0,
      XS_HELD   = 1'b1
   } xfer_state_e;

   // Indices into the sticky indicator array
   localparam int FLG_UNDERFLOW = 0;
   localparam int FLG_RETRY     = 1;
   localparam int FLG_COUNT     = 2;

endpackage

// File: rtl/dpb_sticky_flag.sv
module dpb_sticky_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // A set event wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (rst)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/dpb_sync_fifo.sv
module dpb_sync_fifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              full_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  level_o
);

   localparam bit POW2 = ((1 << PTR_W) == DEPTH);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_wr, do_rd;

   assign full_o  = (cnt_q == FULL_CNT);
   assign empty_o = (cnt_q == '0);
   assign do_wr   = wr_en_i && !full_o;
   assign do_rd   = rd_en_i && !empty_o;

   // Pointer advance: free wrap for power-of-two depths, explicit compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_ptr_nx = wr_ptr_q + PTR_W'(1);
         assign rd_ptr_nx = rd_ptr_q + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_ptr_nx = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + PTR_W'(1);
         assign rd_ptr_nx = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr)
         mem_q[wr_ptr_q] <= wr_data_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_wr)
            wr_ptr_q <= wr_ptr_nx;
         if (do_rd)
            rd_ptr_q <= rd_ptr_nx;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_data_o = mem_q[rd_ptr_q];
   assign level_o   = cnt_q;

endmodule

// File: rtl/dpb_xfer_stage.sv
module dpb_xfer_stage
   import dpb_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid_i,
   input  logic [DATA_W-1:0] up_data_i,
   output logic              up_ready_o,
   input  logic              fifo_full_i,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              refused_o
);

   xfer_state_e       state_q, state_d;
   logic [DATA_W-1:0] hold_q, hold_d;

   always_comb begin
      state_d   = state_q;
      hold_d    = hold_q;
      wr_en_o   = 1'b0;
      wr_data_o = hold_q;
      refused_o = 1'b0;
      unique case (state_q)
         XS_HELD: begin
            if (!fifo_full_i) begin
               wr_en_o = 1'b1;
               state_d = XS_DIRECT;
            end else begin
               refused_o = 1'b1;
            end
         end
         default: begin
            if (up_valid_i) begin
               if (!fifo_full_i) begin
                  wr_en_o   = 1'b1;
                  wr_data_o = up_data_i;
               end else begin
                  hold_d    = up_data_i;
                  state_d   = XS_HELD;
                  refused_o = 1'b1;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= XS_DIRECT;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         hold_q  <= hold_d;
      end
   end

   assign up_ready_o = (state_q == XS_DIRECT);

endmodule

// File: rtl/dpb_playout_stage.sv
module dpb_playout_stage #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              strobe_i,
   input  logic              fifo_empty_i,
   input  logic [DATA_W-1:0] fifo_rdata_i,
   output logic              rd_en_o,
   output logic              starved_o,
   output logic [DATA_W-1:0] dac_data_o,
   output logic              dac_valid_o
);

   logic              run_q;
   logic [DATA_W-1:0] out_q;
   logic              vld_q;
   logic              serve;

   assign serve     = strobe_i && run_q;
   assign rd_en_o   = serve && !fifo_empty_i;
   assign starved_o = serve && fifo_empty_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         out_q <= '0;
         vld_q <= 1'b0;
      end else begin
         run_q <= run_q || start_i;
         vld_q <= rd_en_o;
         if (rd_en_o)
            out_q <= fifo_rdata_i;
      end
   end

   assign dac_data_o  = out_q;
   assign dac_valid_o = vld_q;

endmodule

// File: rtl/dac_playout_buffer.sv
module dac_playout_buffer
   import dpb_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 1024,
   localparam int LVL_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                up_valid_i,
   input  logic [SAMPLE_W-1:0] up_data_i,
   output logic                up_ready_o,
   input  logic                start_i,
   input  logic                dac_strobe_i,
   input  logic                clear_flags_i,
   output logic [SAMPLE_W-1:0] dac_data_o,
   output logic                dac_valid_o,
   output logic                underflow_o,
   output logic                retry_o,
   output logic [LVL_W-1:0]    level_o,
   output logic                full_o,
   output logic                empty_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dac_playout_buffer: DEPTH must be at least 2");
      end
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("dac_playout_buffer: SAMPLE_W must be positive");
      end
   endgenerate

   logic                wr_en, rd_en, refused, starved;
   logic [SAMPLE_W-1:0] wr_data, rd_data;
   logic [FLG_COUNT-1:0] flag_set, flag_val;

   dpb_xfer_stage #(.DATA_W(SAMPLE_W)) u_xfer (
      .clk         (clk),
      .rst         (rst),
      .up_valid_i  (up_valid_i),
      .up_data_i   (up_data_i),
      .up_ready_o  (up_ready_o),
      .fifo_full_i (full_o),
      .wr_en_o     (wr_en),
      .wr_data_o   (wr_data),
      .refused_o   (refused)
   );

   dpb_sync_fifo #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rd_en_i   (rd_en),
      .rd_data_o (rd_data),
      .full_o    (full_o),
      .empty_o   (empty_o),
      .level_o   (level_o)
   );

   dpb_playout_stage #(.DATA_W(SAMPLE_W)) u_play (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .strobe_i     (dac_strobe_i),
      .fifo_empty_i (empty_o),
      .fifo_rdata_i (rd_data),
      .rd_en_o      (rd_en),
      .starved_o    (starved),
      .dac_data_o   (dac_data_o),
      .dac_valid_o  (dac_valid_o)
   );

   assign flag_set[FLG_UNDERFLOW] = starved;
   assign flag_set[FLG_RETRY]     = refused;

   generate
      for (genvar gi = 0; gi < FLG_COUNT; gi++) begin : g_flag
         dpb_sticky_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flag_set[gi]),
            .clr_i  (clear_flags_i),
            .flag_o (flag_val[gi])
         );
      end
   endgenerate

   assign underflow_o = flag_val[FLG_UNDERFLOW];
   assign retry_o     = flag_val[FLG_RETRY];

endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 1024,
   localparam int LVL_W   = $clog2(DEPTH + 1)
) (
   input logic                clk,
   input logic                rst,
   input logic                up_valid_i,
   input logic                up_ready_o,
   input logic                start_i,
   input logic                dac_strobe_i,
   input logic                clear_flags_i,
   input logic [SAMPLE_W-1:0] dac_data_o,
   input logic                dac_valid_o,
   input logic                underflow_o,
   input logic                retry_o,
   input logic [LVL_W-1:0]    level_o,
   input logic                full_o,
   input logic                empty_o
);

   // Independent record of whether a start command has been seen
   logic seen_q;
   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else     seen_q <= seen_q || start_i;
   end

   p_write_direct_r1: assert property (@(posedge clk) disable iff (rst)
      (up_valid_i && up_ready_o && !full_o && !(dac_strobe_i && seen_q))
      |=> (level_o == $past(level_o) + LVL_W'(1)));

   p_no_write_idle_r2: assert property (@(posedge clk) disable iff (rst)
      (!up_valid_i && up_ready_o) |=> (level_o <= $past(level_o)));

   p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (up_valid_i && up_ready_o && full_o) |=> !up_ready_o);

   p_held_release_r3: assert property (@(posedge clk) disable iff (rst)
      (!up_ready_o && !full_o) |=> up_ready_o);

   p_no_play_unstarted_r4: assert property (@(posedge clk) disable iff (rst)
      (dac_strobe_i && !seen_q) |=> !dac_valid_o);

   p_play_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
      (dac_strobe_i && seen_q && !empty_o) |=> dac_valid_o);

   p_underflow_set_r6: assert property (@(posedge clk) disable iff (rst)
      (dac_strobe_i && seen_q && empty_o)
      |=> (underflow_o && $stable(dac_data_o) && !dac_valid_o));

   p_underflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (underflow_o && !clear_flags_i) |=> underflow_o);

   p_retry_set_r8: assert property (@(posedge clk) disable iff (rst)
      ((up_valid_i || !up_ready_o) && full_o) |=> retry_o);

   p_retry_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (retry_o && !clear_flags_i) |=> retry_o);

   p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
      (level_o <= LVL_W'(DEPTH)) && $onehot0({full_o, empty_o}));

endmodule

bind dac_playout_buffer dpb_checker #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_dpb_chk (
   .clk           (clk),
   .rst           (rst),
   .up_valid_i    (up_valid_i),
   .up_ready_o    (up_ready_o),
   .start_i       (start_i),
   .dac_strobe_i  (dac_strobe_i),
   .clear_flags_i (clear_flags_i),
   .dac_data_o    (dac_data_o),
   .dac_valid_o   (dac_valid_o),
   .underflow_o   (underflow_o),
   .retry_o       (retry_o),
   .level_o       (level_o),
   .full_o        (full_o),
   .empty_o       (empty_o)
);

// File: tb/tb_dac_playout_buffer.sv
module tb_dac_playout_buffer;

   localparam int SW = 16;
   localparam int D  = 8;
   localparam int LW = $clog2(D + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          up_valid_i = 1'b0;
   logic [SW-1:0] up_data_i = '0;
   logic          up_ready_o;
   logic          start_i = 1'b0;
   logic          dac_strobe_i = 1'b0;
   logic          clear_flags_i = 1'b0;
   logic [SW-1:0] dac_data_o;
   logic          dac_valid_o;
   logic          underflow_o;
   logic          retry_o;
   logic [LW-1:0] level_o;
   logic          full_o;
   logic          empty_o;

   always #2 clk = ~clk;

   dac_playout_buffer #(.SAMPLE_W(SW), .DEPTH(D)) dut (.*);

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Behavioural reference state
   logic [SW-1:0] q[$];
   bit            m_hold;
   logic [SW-1:0] m_hold_d;
   bit            m_run, m_uf, m_rt, m_dv;
   logic [SW-1:0] m_dd;
   logic [SW-1:0] next_val = 16'h0100;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   task automatic model_reset();
      q.delete();
      m_hold = 0; m_hold_d = '0; m_run = 0; m_uf = 0; m_rt = 0; m_dv = 0; m_dd = '0;
   endtask

   task automatic compare_all();
      chk(up_ready_o == !m_hold, "R3 up_ready", up_ready_o, !m_hold);
      chk(level_o == LW'(q.size()), "R9 level", level_o, q.size());
      chk(full_o == (q.size() == D), "R9 full", full_o, q.size() == D);
      chk(empty_o == (q.size() == 0), "R9 empty", empty_o, q.size() == 0);
      chk(dac_valid_o == m_dv, "R5 dac_valid", dac_valid_o, m_dv);
      chk(dac_data_o == m_dd, "R10 dac_data", dac_data_o, m_dd);
      chk(underflow_o == m_uf, "R7 underflow", underflow_o, m_uf);
      chk(retry_o == m_rt, "R8 retry", retry_o, m_rt);
   endtask

   // One clock: drive inputs, predict, step, compare
   task automatic cyc(input bit uv, input bit st, input bit sb, input bit clr);
      bit full, pop, under, wr, rtset;
      logic [SW-1:0] wd, pd;
      up_valid_i    = uv;
      up_data_i     = next_val;
      start_i       = st;
      dac_strobe_i  = sb;
      clear_flags_i = clr;
      full  = (q.size() == D);
      pop   = sb && m_run && (q.size() != 0);
      under = sb && m_run && (q.size() == 0);
      pd    = pop ? q[0] : '0;
      wr = 0; rtset = 0; wd = '0;
      if (m_hold) begin
         if (!full) begin wr = 1; wd = m_hold_d; end
         else rtset = 1;
      end else if (uv) begin
         if (!full) begin wr = 1; wd = next_val; end
         else rtset = 1;
      end
      @(posedge clk);
      #1;
      cycles++;
      if (m_hold && !full) m_hold = 0;
      else if (!m_hold && uv && full) begin m_hold = 1; m_hold_d = next_val; end
      if (uv && (m_hold_d == next_val || !full) && !(m_hold && !full && wd != next_val))
         ;
      if (!m_hold_was_busy(uv, full, wr, wd)) ;
      if (pop) void'(q.pop_front());
      if (wr) q.push_back(wd);
      m_dv = pop;
      if (pop) m_dd = pd;
      m_uf = under ? 1'b1 : (clr ? 1'b0 : m_uf);
      m_rt = rtset ? 1'b1 : (clr ? 1'b0 : m_rt);
      m_run = m_run || st;
      compare_all();
   endtask

   // Advances the upstream value when the offered sample was taken (direct write or capture)
   function automatic bit m_hold_was_busy(input bit uv, input bit full, input bit wr, input logic [SW-1:0] wd);
      if (uv && up_ready_q) next_val = next_val + 16'h0001;
      return 1'b0;
   endfunction

   bit up_ready_q;
   always @(negedge clk) up_ready_q = up_ready_o;

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      // R11: reset state
      chk(level_o == 0 && empty_o && !full_o, "R11 fifo empty", level_o, 0);
      chk(dac_data_o == 0 && !dac_valid_o, "R11 dac idle", dac_data_o, 0);
      chk(!underflow_o && !retry_o && up_ready_o, "R11 flags/ready", {underflow_o, retry_o, up_ready_o}, 1);

      // R2: idle cycles write nothing
      repeat (3) cyc(0, 0, 0, 0);
      chk(level_o == 0, "R2 idle no write", level_o, 0);

      // R1: one direct write
      cyc(1, 0, 0, 0);
      chk(level_o == 1, "R1 direct write", level_o, 1);

      // Priming with strobes running but no start (R4), overfill to force a hold (R3)
      for (int i = 0; i < 12; i++) begin
         cyc(1, 0, 1, 0);
         chk(!dac_valid_o, "R4 no play before start", dac_valid_o, 0);
      end
      chk(!up_ready_o && full_o, "R3 held while full", up_ready_o, 0);
      chk(retry_o, "R8 retry set", retry_o, 1);

      // Clear while still blocked: set wins (R8)
      cyc(0, 0, 0, 1);
      chk(retry_o, "R8 set beats clear", retry_o, 1);

      // Start with a strobe in the same cycle: not served (R4)
      cyc(0, 1, 1, 0);
      chk(!dac_valid_o, "R4 start-cycle strobe", dac_valid_o, 0);

      // Play out at half rate with the source idle; held sample drains first (R3, R5, R10)
      for (int i = 0; i < 22; i++) cyc(0, 0, i % 2 == 0, 0);
      chk(empty_o, "R6 drained", empty_o, 1);
      chk(underflow_o, "R6 underflow set", underflow_o, 1);

      // R6: further empty strobes keep last sample
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
      chk(underflow_o && !dac_valid_o, "R6 hold output", dac_valid_o, 0);

      // R7: event and clear together keep the flag; clear alone drops it
      cyc(0, 0, 1, 1);
      chk(underflow_o, "R7 set beats clear", underflow_o, 1);
      cyc(0, 0, 0, 1);
      chk(!underflow_o && !retry_o, "R7 clear", underflow_o, 0);

      // Mixed random traffic, start already latched (R5 sticky)
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc(r < 70, 0, ($urandom_range(0, 2) == 0), (r > 95));
      end
      // Let it drain
      for (int i = 0; i < 40; i++) cyc(0, 0, i % 2 == 0, 0);
      chk(empty_o && up_ready_o, "R10 final drain", level_o, 0);

      // Reset again: start must be forgotten (R5 sticky until reset, R11)
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      model_reset();
      compare_all();
      cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 0);
      chk(!dac_valid_o, "R5 start cleared by reset", dac_valid_o, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule